// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs an external analog-to-digital converter core on behalf of software. Software writes a small register set to pick a conversion mode, a channel or a set of channels, and whether the work runs once or repeats. The sequencer then hands the converter one channel at a time over a start/done handshake and files each returned sample in that channel's own result register.

Two modes exist. Single-channel mode converts the channel named in the control register. Scan mode walks every channel whose bit is set in a selection bitmap, lowest index first. In repeat mode either mode restarts by itself: single mode converts the same channel again, and scan mode wraps to the lowest selected channel. A stop request, or clearing the enable bit, ends the run once the channel in flight has finished. Every finished channel sets a sticky end-of-conversion flag, which drives the interrupt line when its enable bit is set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` and `conv_start` are low and the busy bit (CTRL bit 6) is 0.
- R2: Register map (word address `reg_addr`): CTRL at 0 with bit 0 enable, bit 1 mode (0 single, 1 scan), bit 2 repeat, bit 3 interrupt enable, bit 4 start (write 1, reads 0), bit 5 stop (write 1, reads 0), bit 6 busy (read only) and bits 10:8 single-mode channel; SEL at 1 with bits 7:0 the scan bitmap; STAT at 2 with bit 0 the end-of-conversion flag; channel n's data register at 8+n with bits 9:0 the value and bit 10 the new-data flag.
- R3: In single mode a one-shot start converts only the channel in CTRL bits 10:8, exactly once, whatever SEL holds.
- R4: In scan mode a one-shot start converts each channel set in SEL exactly once, in ascending index order; with SEL equal to 0 a start converts nothing.
- R5: With repeat set, single mode converts its channel again and again, and scan mode returns to the lowest selected channel after the highest.
- R6: A start written while the enable bit is 0 launches no conversion.
- R7: A start written while a run is in progress is ignored.
- R8: After a stop request at most one further conversion is issued, and the busy bit then falls to 0 with no later `conv_start`.
- R9: Each completed channel sets STAT bit 0; it stays set until software writes 1 to it, and a completion in the same cycle as that write leaves it set.
- R10: `irq` is high exactly when STAT bit 0 and the interrupt enable bit are both 1.
- R11: A completion stores `conv_data` in the channel's data register and sets its new-data flag; a read of that register clears the flag, except when the same channel completes in the read cycle, in which case the flag stays set with the new value.
- R12: `conv_start` is a one-cycle pulse carrying the channel on `conv_chan`; no new pulse is issued until `conv_done` returns for the outstanding channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a data register's new flag) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 11 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | End-of-conversion interrupt |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | 3 | Channel for the converter |
| conv_done | input | 1 | Converter finished, `conv_data` valid |
| conv_data | input | 10 | Converter result |

## Verification
Two pairs of functions can land on the same clock edge: the completion of a channel and the software clear of the end-of-conversion flag, and the completion of a channel and a read of that channel's data register. The bench drives the converter stub and watches `conv_done` at the falling edge; in the cycle it sees the done pulse it places the clearing write, or the read, so that both are sampled by one rising edge. It judges the result by reading STAT back as 1, and by reading the data register again to find the new flag still set with the fresh value, then cleared by the following read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  // register word addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_SEL  = 1;
  localparam int unsigned A_STAT = 2;

  // CTRL bit positions
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_MODE  = 1;
  localparam int unsigned B_RPT   = 2;
  localparam int unsigned B_IEN   = 3;
  localparam int unsigned B_START = 4;
  localparam int unsigned B_STOP  = 5;
  localparam int unsigned B_BUSY  = 6;
  localparam int unsigned B_CHAN  = 8;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3,
  parameter int AW  = 4,
  parameter int RW  = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [RW-1:0]  reg_wdata,
  input  logic [RW-1:0]  data_word,
  input  logic           done_evt,
  input  logic           busy,
  output logic           cfg_en,
  output logic           cfg_mode,
  output logic           cfg_rpt,
  output logic           cfg_ien,
  output logic [CW-1:0]  cfg_chan,
  output logic [NCH-1:0] cfg_sel,
  output logic           start_q,
  output logic           stop_q,
  output logic           eoc,
  output logic           eoc_clr,
  output logic           irq,
  output logic [RW-1:0]  reg_rdata
);

  logic wr_ctrl, wr_sel, wr_stat;

  assign wr_ctrl = reg_wr && (reg_addr == AW'(A_CTRL));
  assign wr_sel  = reg_wr && (reg_addr == AW'(A_SEL));
  assign wr_stat = reg_wr && (reg_addr == AW'(A_STAT));
  assign eoc_clr = wr_stat && reg_wdata[0];
  assign irq     = eoc && cfg_ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      cfg_mode <= 1'b0;
      cfg_rpt  <= 1'b0;
      cfg_ien  <= 1'b0;
      cfg_chan <= '0;
      cfg_sel  <= '0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      eoc      <= 1'b0;
    end else begin
      start_q <= wr_ctrl && reg_wdata[B_START];
      stop_q  <= wr_ctrl && reg_wdata[B_STOP];
      if (wr_ctrl) begin
        cfg_en   <= reg_wdata[B_EN];
        cfg_mode <= reg_wdata[B_MODE];
        cfg_rpt  <= reg_wdata[B_RPT];
        cfg_ien  <= reg_wdata[B_IEN];
        cfg_chan <= reg_wdata[B_CHAN +: CW];
      end
      if (wr_sel) cfg_sel <= reg_wdata[NCH-1:0];
      // a completion outranks a software clear
      if (done_evt)     eoc <= 1'b1;
      else if (eoc_clr) eoc <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[AW-1]) begin
      reg_rdata = data_word;
    end else if (reg_addr == AW'(A_CTRL)) begin
      reg_rdata[B_EN]          = cfg_en;
      reg_rdata[B_MODE]        = cfg_mode;
      reg_rdata[B_RPT]         = cfg_rpt;
      reg_rdata[B_IEN]         = cfg_ien;
      reg_rdata[B_BUSY]        = busy;
      reg_rdata[B_CHAN +: CW]  = cfg_chan;
    end else if (reg_addr == AW'(A_SEL)) begin
      reg_rdata[NCH-1:0] = cfg_sel;
    end else if (reg_addr == AW'(A_STAT)) begin
      reg_rdata[0] = eoc;
    end
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_mode,
  input  logic           cfg_rpt,
  input  logic [CW-1:0]  cfg_chan,
  input  logic [NCH-1:0] cfg_sel,
  input  logic           start_q,
  input  logic           stop_q,
  input  logic           conv_done,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  output logic           busy,
  output logic           in_wait,
  output logic           done_evt
);

  // lowest set index at or above floor: {found, index}
  function automatic logic [CW:0] pick_from(input logic [NCH-1:0] map,
                                            input logic [CW:0]    floor);
    logic [CW:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (map[i] && (i >= int'(floor))) r = {1'b1, CW'(i)};
    end
    return r;
  endfunction

  seq_state_e  state;
  logic [CW-1:0] cur;
  logic          stop_pend;
  logic [CW:0]   first_pick, next_pick;
  logic          halt;

  assign first_pick = pick_from(cfg_sel, '0);
  assign next_pick  = pick_from(cfg_sel, (CW+1)'(cur) + 1'b1);

  assign conv_start = (state == ST_ISSUE);
  assign conv_chan  = cur;
  assign busy       = (state != ST_IDLE);
  assign in_wait    = (state == ST_WAIT);
  assign done_evt   = in_wait && conv_done;
  assign halt       = stop_pend || stop_q || !cfg_en || !cfg_rpt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= '0;
      stop_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (start_q && cfg_en) begin
            if (!cfg_mode) begin
              cur   <= cfg_chan;
              state <= ST_ISSUE;
            end else if (first_pick[CW]) begin
              cur   <= first_pick[CW-1:0];
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (stop_q) stop_pend <= 1'b1;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (stop_q) stop_pend <= 1'b1;
          if (conv_done) begin
            if (!cfg_mode) begin
              state <= halt ? ST_IDLE : ST_ISSUE;
            end else if (stop_pend || stop_q || !cfg_en) begin
              state <= ST_IDLE;
            end else if (next_pick[CW]) begin
              cur   <= next_pick[CW-1:0];
              state <= ST_ISSUE;
            end else if (cfg_rpt && first_pick[CW]) begin
              cur   <= first_pick[CW-1:0];
              state <= ST_ISSUE;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int NCH = 8,
  parameter int CW  = 3,
  parameter int DW  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CW-1:0]  wchan,
  input  logic [DW-1:0]  wdata,
  input  logic           rd_hit,
  input  logic [CW-1:0]  ridx,
  output logic [DW-1:0]  rval,
  output logic           rnew,
  output logic [NCH-1:0] new_flags
);

  logic [DW-1:0] vals [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vals[g]      <= '0;
        new_flags[g] <= 1'b0;
      end else if (we && (wchan == CW'(g))) begin
        vals[g]      <= wdata;
        new_flags[g] <= 1'b1;
      end else if (rd_hit && (ridx == CW'(g))) begin
        new_flags[g] <= 1'b0;
      end
    end
  end

  assign rval = vals[ridx];
  assign rnew = new_flags[ridx];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [$clog2(NCH):0]     reg_addr,
  input  logic [((DW+1 > 8+$clog2(NCH)) ? DW+1 : 8+$clog2(NCH))-1:0] reg_wdata,
  output logic [((DW+1 > 8+$clog2(NCH)) ? DW+1 : 8+$clog2(NCH))-1:0] reg_rdata,
  output logic                     irq,
  output logic                     conv_start,
  output logic [$clog2(NCH)-1:0]   conv_chan,
  input  logic                     conv_done,
  input  logic [DW-1:0]            conv_data
);

  localparam int CW = $clog2(NCH);
  localparam int AW = CW + 1;
  localparam int RW = (DW + 1 > 8 + CW) ? DW + 1 : 8 + CW;

  logic           cfg_en, cfg_mode, cfg_rpt, cfg_ien;
  logic [CW-1:0]  cfg_chan;
  logic [NCH-1:0] cfg_sel;
  logic           start_q, stop_q, eoc, eoc_clr;
  logic           busy, in_wait, done_evt;
  logic [DW-1:0]  rval;
  logic           rnew;
  logic [NCH-1:0] new_flags;
  logic [RW-1:0]  data_word;

  always_comb begin
    data_word            = '0;
    data_word[DW-1:0]    = rval;
    data_word[DW]        = rnew;
  end

  adc_seq_regs #(.NCH(NCH), .CW(CW), .AW(AW), .RW(RW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .data_word (data_word),
    .done_evt  (done_evt),
    .busy      (busy),
    .cfg_en    (cfg_en),
    .cfg_mode  (cfg_mode),
    .cfg_rpt   (cfg_rpt),
    .cfg_ien   (cfg_ien),
    .cfg_chan  (cfg_chan),
    .cfg_sel   (cfg_sel),
    .start_q   (start_q),
    .stop_q    (stop_q),
    .eoc       (eoc),
    .eoc_clr   (eoc_clr),
    .irq       (irq),
    .reg_rdata (reg_rdata)
  );

  adc_seq_fsm #(.NCH(NCH), .CW(CW)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_mode   (cfg_mode),
    .cfg_rpt    (cfg_rpt),
    .cfg_chan   (cfg_chan),
    .cfg_sel    (cfg_sel),
    .start_q    (start_q),
    .stop_q     (stop_q),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .busy       (busy),
    .in_wait    (in_wait),
    .done_evt   (done_evt)
  );

  adc_seq_results #(.NCH(NCH), .CW(CW), .DW(DW)) i_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (done_evt),
    .wchan     (conv_chan),
    .wdata     (conv_data),
    .rd_hit    (reg_rd && reg_addr[AW-1]),
    .ridx      (reg_addr[CW-1:0]),
    .rval      (rval),
    .rnew      (rnew),
    .new_flags (new_flags)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_start,
  input logic           conv_done,
  input logic [CW-1:0]  conv_chan,
  input logic           busy,
  input logic           in_wait,
  input logic           done_evt,
  input logic           cfg_en,
  input logic           eoc,
  input logic           eoc_clr,
  input logic [NCH-1:0] new_flags
);

  // R12: start is a single-cycle pulse
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R12: no new start while a conversion is outstanding
  a_r12_no_start_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !conv_done) |=> !conv_start);

  // R6: a run only begins when enabled
  a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_en));

  // R9: every completion leaves the flag set
  a_r9_done_sets_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> eoc);

  // R9: flag holds until cleared by software
  a_r9_eoc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !eoc_clr) |=> eoc);

  // R11: completion marks the channel's data as new
  a_r11_done_sets_new: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> new_flags[$past(conv_chan)]);

endmodule

bind adc_seq_ctrl adc_seq_checker #(.NCH(NCH), .CW(CW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .conv_chan  (conv_chan),
  .busy       (busy),
  .in_wait    (in_wait),
  .done_evt   (done_evt),
  .cfg_en     (cfg_en),
  .eoc        (eoc),
  .eoc_clr    (eoc_clr),
  .new_flags  (new_flags)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [10:0] reg_wdata = '0;
  logic [10:0] reg_rdata;
  logic        irq, conv_start, conv_done;
  logic [2:0]  conv_chan;
  logic [9:0]  conv_data;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data)
  );

  // converter stub: fixed latency, unique data per conversion
  logic [2:0] log_ch [256];
  int         log_n = 0;
  logic [9:0] last_data [8];
  logic       busy_m = 1'b0;
  int         cnt = 0;
  logic [2:0] ch_m = '0;
  logic [6:0] seq = '0;

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) begin
      busy_m <= 1'b0;
    end else if (conv_start && !busy_m) begin
      busy_m <= 1'b1;
      cnt    <= LAT;
      ch_m   <= conv_chan;
      if (log_n < 256) log_ch[log_n] <= conv_chan;
      log_n  <= log_n + 1;
    end else if (busy_m) begin
      if (cnt == 0) begin
        conv_done       <= 1'b1;
        conv_data       <= {ch_m, seq};
        last_data[ch_m] <= {ch_m, seq};
        seq             <= seq + 1'b1;
        busy_m          <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] ctl(input bit en, input bit mode, input bit rpt,
                                      input bit ien, input bit start, input bit stop,
                                      input logic [2:0] ch);
    return {ch, 2'b00, stop, start, ien, rpt, mode, en};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [10:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [10:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [10:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(4'd0, v);
      if (!v[6]) break;
    end
  endtask

  task automatic wait_done_negedge();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (conv_done) break;
    end
  endtask

  // mode, channel, bitmap
  localparam logic [11:0] VECS [7] = '{
    {1'b0, 3'd5, 8'h00},
    {1'b0, 3'd0, 8'hFF},
    {1'b1, 3'd0, 8'hA5},
    {1'b1, 3'd3, 8'h80},
    {1'b1, 3'd0, 8'hFF},
    {1'b1, 3'd6, 8'h01},
    {1'b0, 3'd7, 8'h3C}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] v;
    int base, n, exp_n;
    logic [2:0] exp_ch [8];

    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk("R1 irq", irq, 0);
    chk("R1 conv_start", conv_start, 0);
    rst_n = 1'b1;
    rd(4'd0, v); chk("R1 CTRL", v, 0);
    rd(4'd1, v); chk("R1 SEL", v, 0);
    rd(4'd2, v); chk("R1 STAT", v, 0);
    rd(4'd8, v); chk("R1 DATA0", v, 0);

    // R2 R3 R4: vector table of one-shot runs
    for (int k = 0; k < 7; k++) begin
      logic mode;
      logic [2:0] ch;
      logic [7:0] sel;
      {mode, ch, sel} = VECS[k];
      exp_n = 0;
      if (!mode) begin
        exp_ch[0] = ch; exp_n = 1;
      end else begin
        for (int b = 0; b < 8; b++) if (sel[b]) begin exp_ch[exp_n] = 3'(b); exp_n++; end
      end
      wr(4'd1, {3'b0, sel});
      rd(4'd1, v); chk("R2 SEL readback", v, {3'b0, sel});
      base = log_n;
      wr(4'd0, ctl(1, mode, 0, 0, 1, 0, ch));
      wait_idle();
      chk(mode ? "R4 scan count" : "R3 single count", log_n - base, exp_n);
      for (int j = 0; j < exp_n; j++) begin
        chk(mode ? "R4 scan order" : "R3 single channel", log_ch[base + j], exp_ch[j]);
        rd(4'(8 + exp_ch[j]), v);
        chk("R11 data value", v[9:0], last_data[exp_ch[j]]);
        chk("R11 new flag set", v[10], 1);
      end
      rd(4'(8 + exp_ch[0]), v);
      chk("R11 new cleared by read", v[10], 0);
    end

    // R4: empty bitmap
    wr(4'd1, 11'd0);
    base = log_n;
    wr(4'd0, ctl(1, 1, 0, 0, 1, 0, 0));
    repeat (20) @(negedge clk);
    chk("R4 empty bitmap no conversion", log_n - base, 0);
    rd(4'd0, v); chk("R4 empty bitmap not busy", v[6], 0);

    // R6: disabled start
    base = log_n;
    wr(4'd0, ctl(0, 0, 0, 0, 1, 0, 3'd2));
    repeat (20) @(negedge clk);
    chk("R6 disabled start ignored", log_n - base, 0);

    // R7: start during a run
    base = log_n;
    wr(4'd0, ctl(1, 0, 0, 0, 1, 0, 3'd3));
    wr(4'd0, ctl(1, 0, 0, 0, 1, 0, 3'd3));
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R7 second start ignored", log_n - base, 1);

    // R5 R8: repeating scan, wrap and stop
    wr(4'd1, 11'h092);
    base = log_n;
    wr(4'd0, ctl(1, 1, 1, 0, 1, 0, 0));
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (log_n - base >= 5) break;
    end
    wr(4'd0, ctl(1, 1, 1, 0, 0, 1, 0));
    n = log_n - base;
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R8 at most one after stop", (log_n - base - n) <= 1, 1);
    rd(4'd0, v); chk("R8 busy cleared", v[6], 0);
    chk("R5 scan wrapped", (log_n - base) >= 4, 1);
    for (int j = 0; j < log_n - base; j++) begin
      logic [2:0] e;
      e = (j % 3 == 0) ? 3'd1 : ((j % 3 == 1) ? 3'd4 : 3'd7);
      chk("R5 scan repeat order", log_ch[base + j], e);
    end

    // R5: repeating single channel
    base = log_n;
    wr(4'd0, ctl(1, 0, 1, 0, 1, 0, 3'd2));
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (log_n - base >= 3) break;
    end
    chk("R5 single repeats", (log_n - base) >= 3, 1);
    wr(4'd0, ctl(1, 0, 1, 0, 0, 1, 3'd2));
    wait_idle();
    for (int j = 0; j < log_n - base; j++) chk("R5 single same channel", log_ch[base + j], 2);

    // R9 R10: sticky flag and interrupt
    wr(4'd2, 11'd1);
    rd(4'd2, v); chk("R9 W1C clears", v[0], 0);
    wr(4'd0, ctl(1, 0, 0, 0, 1, 0, 3'd1));
    wait_idle();
    rd(4'd2, v); chk("R9 set on completion", v[0], 1);
    #1 chk("R10 irq masked", irq, 0);
    wr(4'd2, 11'd0);
    rd(4'd2, v); chk("R9 write 0 keeps flag", v[0], 1);
    wr(4'd0, ctl(1, 0, 0, 1, 0, 0, 3'd1));
    #1 chk("R10 irq enabled", irq, 1);
    wr(4'd2, 11'd1);
    #1 chk("R10 irq after clear", irq, 0);

    // R9: clear in the completion cycle
    wr(4'd0, ctl(1, 0, 0, 1, 1, 0, 3'd6));
    wait_done_negedge();
    reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 11'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(4'd2, v); chk("R9 set wins over clear", v[0], 1);
    #1 chk("R10 irq stays", irq, 1);
    wait_idle();

    // R11: read in the completion cycle
    wr(4'd0, ctl(1, 0, 0, 0, 1, 0, 3'd4));
    wait_done_negedge();
    reg_rd = 1'b1; reg_addr = 4'd12;
    @(negedge clk);
    reg_rd = 1'b0;
    rd(4'd12, v);
    chk("R11 new kept on same-cycle read", v[10], 1);
    chk("R11 fresh value", v[9:0], last_data[4]);
    rd(4'd12, v); chk("R11 later read clears", v[10], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule